// File: doc/BRIEF.md
# Selectable Event Counter Bank

This block is the counting core of a memory-controller performance monitor. It holds a bank of general-purpose 32-bit counters and one wide free-running cycle counter. Each general counter owns an 8-bit selection slot that names one line of a 64-wide event pulse vector and carries an enable bit. While counting is started, an enabled counter adds one on every clock in which its chosen event line is high.

Software drives the block through a simple register port. A global control word starts, stops or clears all counting. A counter can be seeded by first writing a selection code to the test-select register and then writing the initial value to the shared preload register. When a general counter rolls over from all-ones to zero, the block raises a one-cycle overflow pulse for that counter. Writes are always accepted. A read returns its data with `rd_valid` exactly one cycle after `rd_en`, so the port never applies back-pressure and has no ready signal.

Top module: `perf_event_bank`

## Requirements
- R1: After reset, every counter, the cycle counter, every selection slot and the overflow outputs are zero, and counting is stopped.
- R2: A write to the control word at 0xC00 starts counting when bit 0 is set and stops it when bit 1 is set. When both bits are set, stop wins. Reading 0xC00 returns the started state in bit 0.
- R3: A control write with bit 2 set clears all general counters and the cycle counter, and leaves counting stopped.
- R4: Counter n is selected by the word at 0xC68 + 4*(n/4), in byte 8*(n mod 4). Within that byte, bit 7 is the enable and bits 5:0 are the event code. Bit 6 reads back as zero.
- R5: While counting is started, counter n increments by one on each clock in which its slot is enabled and `evt_in[code]` is high. Otherwise the counter holds its value.
- R6: Counter n reads at 0xC78 + 4*n. Each read presents `rd_data` with `rd_valid` one cycle after `rd_en`.
- R7: The 56-bit cycle counter adds one on every clock while counting is started. Its upper 24 bits read at 0xC10, zero-extended, and its lower 32 bits read at 0xC14.
- R8: With the value 19 + n in the test-select register at 0xC08, a write to the preload register at 0xC0C loads the written value into counter n. The last preload value reads back at 0xC0C.
- R9: A preload write while the test-select value is outside 19..19+15 (including 0) changes no counter.
- R10: A counter that increments from 0xFFFFFFFF wraps to zero. In the same cycle, its `ovf_pulse` bit is high for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 12 | Register read byte address |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | High one cycle after rd_en |
| evt_in | input | 64 | Event pulse lines indexed by slot code |
| ovf_pulse | output | 16 | Per-counter wrap pulse |

## Verification
The following results land on the first clock edge after the stimulus: a register write, an event pulse, a preload, and an overflow pulse that appears together with the wrapped zero value. Read data arrives one edge after `rd_en`. The bench drives every input on a falling edge and samples on the next falling edge, so each result is observed exactly one edge after its cause. Cycle-count expectations are derived by counting the rising edges between the edge that sets the started state and the edge that clears it.

// File: rtl/pevb_pkg.sv
package pevb_pkg;
  parameter int unsigned ADDR_W = 12;
  parameter int unsigned DATA_W = 32;
  parameter int unsigned SLOT_W = 8;
  parameter int unsigned TSEL_BASE = 19;

  localparam logic [ADDR_W-1:0] OFS_CTRL     = 12'hC00;
  localparam logic [ADDR_W-1:0] OFS_TSEL     = 12'hC08;
  localparam logic [ADDR_W-1:0] OFS_PRELOAD  = 12'hC0C;
  localparam logic [ADDR_W-1:0] OFS_CYC_HI   = 12'hC10;
  localparam logic [ADDR_W-1:0] OFS_CYC_LO   = 12'hC14;
  localparam logic [ADDR_W-1:0] OFS_SEL_BASE = 12'hC68;
  localparam logic [ADDR_W-1:0] OFS_CNT_BASE = 12'hC78;

  localparam int unsigned SLOTS_PER_WORD = DATA_W / SLOT_W;

  localparam int unsigned CTRL_START_BIT = 0;
  localparam int unsigned CTRL_STOP_BIT  = 1;
  localparam int unsigned CTRL_CLEAR_BIT = 2;
endpackage

// File: rtl/pevb_slot_regs.sv
module pevb_slot_regs
  import pevb_pkg::*;
#(
  parameter int unsigned NUM_CNT = 16,
  parameter int unsigned CODE_W  = 6,
  localparam int unsigned WORDS  = NUM_CNT / SLOTS_PER_WORD,
  localparam int unsigned WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [WIDX_W-1:0]                wr_idx,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_CNT-1:0]               slot_en,
  output logic [NUM_CNT-1:0][CODE_W-1:0]   slot_code,
  output logic [WORDS-1:0][DATA_W-1:0]     word_rd
);
  for (genvar n = 0; n < NUM_CNT; n++) begin : g_slot
    localparam int unsigned WORD = n / SLOTS_PER_WORD;
    localparam int unsigned LSB  = SLOT_W * (n % SLOTS_PER_WORD);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_en[n]   <= 1'b0;
        slot_code[n] <= '0;
      end else if (wr_en && wr_idx == WIDX_W'(WORD)) begin
        slot_en[n]   <= wr_data[LSB + SLOT_W - 1];
        slot_code[n] <= wr_data[LSB +: CODE_W];
      end
    end

    assign word_rd[WORD][LSB +: SLOT_W] =
      {slot_en[n], {(SLOT_W - 1 - CODE_W){1'b0}}, slot_code[n]};

    // R4
    slot_enable_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == WIDX_W'(WORD)) |=> (slot_en[n] == $past(wr_data[LSB + SLOT_W - 1])));
  end
endmodule

// File: rtl/pevb_counter.sv
module pevb_counter
  import pevb_pkg::*;
#(
  parameter int unsigned CODE_W = 6,
  localparam int unsigned EVT_W = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  input  logic [EVT_W-1:0]  evt_in,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] count,
  output logic              ovf
);
  logic hit;
  assign hit = run && en && evt_in[code];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      ovf <= 1'b0;
      if (clr) begin
        count <= '0;
      end else if (load) begin
        count <= load_val;
      end else if (hit) begin
        count <= count + 1'b1;
        ovf   <= &count;
      end
    end
  end

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load && !clr) |=> $stable(count));

  // R10
  ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (count == '0));

  // R8
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (count == $past(load_val)));
endmodule

// File: rtl/pevb_cycle.sv
module pevb_cycle #(
  parameter int unsigned CYC_W = 56
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  output logic [CYC_W-1:0] cyc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cyc <= '0;
    else if (clr) cyc <= '0;
    else if (run) cyc <= cyc + 1'b1;
  end

  // R7
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr) |=> (cyc == $past(cyc) + 1'b1));

  // R7
  cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cyc));
endmodule

// File: rtl/perf_event_bank.sv
module perf_event_bank
  import pevb_pkg::*;
#(
  parameter int unsigned NUM_CNT = 16,
  parameter int unsigned CODE_W  = 6,
  parameter int unsigned CYC_W   = 56,
  localparam int unsigned EVT_W  = 1 << CODE_W,
  localparam int unsigned IDX_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1,
  localparam int unsigned WORDS  = NUM_CNT / SLOTS_PER_WORD,
  localparam int unsigned WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_valid,
  input  logic [EVT_W-1:0]   evt_in,
  output logic [NUM_CNT-1:0] ovf_pulse
);
  localparam logic [ADDR_W-1:0] SEL_END = OFS_SEL_BASE + ADDR_W'(4 * WORDS);
  localparam logic [ADDR_W-1:0] CNT_END = OFS_CNT_BASE + ADDR_W'(4 * NUM_CNT);

  // write decode
  logic ctrl_wr, tsel_wr, pre_wr, sel_wr, clr_all;
  logic [ADDR_W-1:0] wr_sel_off;
  logic [WIDX_W-1:0] wr_sel_idx;

  assign ctrl_wr    = wr_en && (wr_addr == OFS_CTRL);
  assign tsel_wr    = wr_en && (wr_addr == OFS_TSEL);
  assign pre_wr     = wr_en && (wr_addr == OFS_PRELOAD);
  assign sel_wr     = wr_en && (wr_addr >= OFS_SEL_BASE) && (wr_addr < SEL_END) &&
                      (wr_addr[1:0] == 2'b00);
  assign wr_sel_off = wr_addr - OFS_SEL_BASE;
  assign wr_sel_idx = wr_sel_off[WIDX_W+1:2];
  assign clr_all    = ctrl_wr && wr_data[CTRL_CLEAR_BIT];

  // global run state: clear and stop dominate start
  logic running;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
    end else if (ctrl_wr) begin
      if (wr_data[CTRL_CLEAR_BIT] || wr_data[CTRL_STOP_BIT]) running <= 1'b0;
      else if (wr_data[CTRL_START_BIT])                      running <= 1'b1;
    end
  end

  // test-select and preload registers
  logic [DATA_W-1:0] tsel_q, pre_q, tsel_rel;
  logic              tsel_valid;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsel_q <= '0;
      pre_q  <= '0;
    end else begin
      if (tsel_wr) tsel_q <= wr_data;
      if (pre_wr)  pre_q  <= wr_data;
    end
  end
  assign tsel_rel   = tsel_q - DATA_W'(TSEL_BASE);
  assign tsel_valid = (tsel_q >= DATA_W'(TSEL_BASE)) && (tsel_rel < DATA_W'(NUM_CNT));

  // selection slots
  logic [NUM_CNT-1:0]             slot_en;
  logic [NUM_CNT-1:0][CODE_W-1:0] slot_code;
  logic [WORDS-1:0][DATA_W-1:0]   sel_word;

  pevb_slot_regs #(
    .NUM_CNT (NUM_CNT),
    .CODE_W  (CODE_W)
  ) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (sel_wr),
    .wr_idx    (wr_sel_idx),
    .wr_data   (wr_data),
    .slot_en   (slot_en),
    .slot_code (slot_code),
    .word_rd   (sel_word)
  );

  // general counters
  logic [NUM_CNT-1:0]             load_vec;
  logic [NUM_CNT-1:0][DATA_W-1:0] cnt_q;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    assign load_vec[i] = pre_wr && tsel_valid && (tsel_rel[IDX_W-1:0] == IDX_W'(i));

    pevb_counter #(
      .CODE_W (CODE_W)
    ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr_all),
      .run      (running),
      .en       (slot_en[i]),
      .code     (slot_code[i]),
      .evt_in   (evt_in),
      .load     (load_vec[i]),
      .load_val (wr_data),
      .count    (cnt_q[i]),
      .ovf      (ovf_pulse[i])
    );
  end

  // cycle counter
  logic [CYC_W-1:0]    cyc_q;
  logic [2*DATA_W-1:0] cyc_ext;

  pevb_cycle #(
    .CYC_W (CYC_W)
  ) u_cyc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_all),
    .run   (running),
    .cyc   (cyc_q)
  );
  assign cyc_ext = {{(2*DATA_W - CYC_W){1'b0}}, cyc_q};

  // read path: one registered stage
  logic [ADDR_W-1:0] rd_cnt_off, rd_sel_off;
  logic [DATA_W-1:0] rd_mux;
  assign rd_cnt_off = rd_addr - OFS_CNT_BASE;
  assign rd_sel_off = rd_addr - OFS_SEL_BASE;

  always_comb begin
    rd_mux = '0;
    if (rd_addr[1:0] == 2'b00) begin
      if (rd_addr == OFS_CTRL)          rd_mux = {{(DATA_W-1){1'b0}}, running};
      else if (rd_addr == OFS_TSEL)     rd_mux = tsel_q;
      else if (rd_addr == OFS_PRELOAD)  rd_mux = pre_q;
      else if (rd_addr == OFS_CYC_HI)   rd_mux = cyc_ext[2*DATA_W-1:DATA_W];
      else if (rd_addr == OFS_CYC_LO)   rd_mux = cyc_ext[DATA_W-1:0];
      else if (rd_addr >= OFS_SEL_BASE && rd_addr < SEL_END)
        rd_mux = sel_word[rd_sel_off[WIDX_W+1:2]];
      else if (rd_addr >= OFS_CNT_BASE && rd_addr < CNT_END)
        rd_mux = cnt_q[rd_cnt_off[IDX_W+1:2]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  // R2
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wr_data[CTRL_STOP_BIT]) |=> !running);

  // R3
  clear_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (!running && cyc_q == '0));

  // R9
  preload_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_vec));

  // R9
  preload_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_wr || !tsel_valid) |-> (load_vec == '0));

  // R6
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
endmodule

// File: tb/perf_event_bank_tb.sv
`timescale 1ns/1ps
module perf_event_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [11:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [63:0] evt_in = '0;
  logic [15:0] ovf_pulse;

  int checks = 0;
  int failures = 0;
  logic [31:0] sel_sh [4];

  always #2.5 clk = ~clk;

  perf_event_bank u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .evt_in(evt_in), .ovf_pulse(ovf_pulse)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all tasks are entered and left on a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd_cnt(input int n, output logic [31:0] d);
    rd(12'hC78 + 12'(4 * n), d);
  endtask

  task automatic set_slot(input int n, input logic en, input logic [5:0] code);
    sel_sh[n/4][8*(n%4) +: 8] = {en, 1'b0, code};
    wr(12'hC68 + 12'(4 * (n/4)), sel_sh[n/4]);
  endtask

  task automatic pulse(input logic [63:0] mask, input int n);
    for (int k = 0; k < n; k++) begin
      evt_in = mask;
      @(negedge clk);
    end
    evt_in = '0;
  endtask

  task automatic clear_all();
    wr(12'hC00, 32'h4);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 ovf after reset", ovf_pulse, 0);
    rd_en = 1'b1; rd_addr = 12'hC00;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R6 rd_valid one cycle after rd_en", rd_valid, 1);
    chk("R1 ctrl started state", rd_data, 0);
    rd_cnt(9, d);        chk("R1 counter 9", d, 0);
    rd(12'hC14, d);      chk("R1 cycle low", d, 0);
    rd(12'hC6C, d);      chk("R1 slot word 1", d, 0);
  endtask

  task automatic t_slot_layout();
    logic [31:0] d;
    set_slot(6, 1'b1, 6'h2A);
    set_slot(7, 1'b0, 6'h3F);
    rd(12'hC6C, d);
    chk("R4 slot word layout", d, 32'h3F_AA_0000);
    set_slot(6, 1'b0, 6'h00);
    set_slot(7, 1'b0, 6'h00);
  endtask

  task automatic t_stop_wins();
    logic [31:0] d;
    clear_all();
    set_slot(0, 1'b1, 6'd1);
    wr(12'hC00, 32'h3);
    rd(12'hC00, d);         chk("R2 start+stop leaves stopped", d, 0);
    pulse(64'h2, 3);
    rd_cnt(0, d);           chk("R2 no count while stopped", d, 0);
    wr(12'hC00, 32'h1);
    rd(12'hC00, d);         chk("R2 start sets started state", d, 1);
    wr(12'hC00, 32'h2);
    rd(12'hC00, d);         chk("R2 stop clears started state", d, 0);
    set_slot(0, 1'b0, 6'd0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    clear_all();
    set_slot(2, 1'b1, 6'd10);
    set_slot(7, 1'b1, 6'd10);
    set_slot(13, 1'b1, 6'd40);
    set_slot(4, 1'b0, 6'd10);
    wr(12'hC00, 32'h1);
    pulse(64'h1 << 10, 5);
    pulse((64'h1 << 40) | (64'h1 << 10), 3);
    @(negedge clk);
    wr(12'hC00, 32'h2);
    rd_cnt(2, d);   chk("R5 counter 2 on code 10", d, 8);
    rd_cnt(7, d);   chk("R5 counter 7 shares code 10", d, 8);
    rd_cnt(13, d);  chk("R5 counter 13 on code 40", d, 3);
    rd_cnt(4, d);   chk("R5 disabled slot holds", d, 0);
    rd_cnt(0, d);   chk("R6 unselected counter reads zero", d, 0);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(12'hC00, 32'h1);
    wr(12'hC00, 32'h5);
    rd(12'hC00, d);   chk("R3 clear leaves stopped", d, 0);
    rd_cnt(2, d);     chk("R3 counter 2 cleared", d, 0);
    rd(12'hC14, d);   chk("R3 cycle counter cleared", d, 0);
    pulse(64'h1 << 10, 2);
    rd_cnt(7, d);     chk("R3 no count after clear", d, 0);
  endtask

  task automatic t_cycle();
    logic [31:0] d;
    clear_all();
    wr(12'hC00, 32'h1);
    repeat (10) @(negedge clk);
    wr(12'hC00, 32'h2);
    rd(12'hC14, d);   chk("R7 cycle low after 11 running edges", d, 11);
    rd(12'hC10, d);   chk("R7 cycle high part", d, 0);
    repeat (3) @(negedge clk);
    rd(12'hC14, d);   chk("R7 cycle holds when stopped", d, 11);
  endtask

  task automatic t_preload();
    logic [31:0] d;
    clear_all();
    wr(12'hC08, 32'd19 + 32'd11);
    wr(12'hC0C, 32'hCAFE_0123);
    wr(12'hC08, 32'd0);
    rd_cnt(11, d);    chk("R8 preload counter 11", d, 32'hCAFE_0123);
    rd(12'hC0C, d);   chk("R8 preload register readback", d, 32'hCAFE_0123);
    rd_cnt(10, d);    chk("R8 neighbour untouched", d, 0);
    wr(12'hC0C, 32'h5555_AAAA);
    rd_cnt(11, d);    chk("R9 preload with select zero", d, 32'hCAFE_0123);
    wr(12'hC08, 32'd35);
    wr(12'hC0C, 32'h7777_0000);
    wr(12'hC08, 32'd18);
    wr(12'hC0C, 32'h1111_0000);
    wr(12'hC08, 32'd0);
    for (int n = 0; n < 16; n++) begin
      rd_cnt(n, d);
      chk($sformatf("R9 out-of-range select, counter %0d", n), d,
          (n == 11) ? 32'hCAFE_0123 : 32'h0);
    end
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    clear_all();
    set_slot(5, 1'b1, 6'd63);
    wr(12'hC08, 32'd24);
    wr(12'hC0C, 32'hFFFF_FFFE);
    wr(12'hC08, 32'd0);
    wr(12'hC00, 32'h1);
    evt_in = 64'h1 << 63;
    @(negedge clk);
    chk("R10 no pulse before wrap", ovf_pulse, 0);
    @(negedge clk);
    chk("R10 pulse on wrap", ovf_pulse, 16'h0020);
    evt_in = '0;
    @(negedge clk);
    chk("R10 pulse lasts one cycle", ovf_pulse, 0);
    wr(12'hC00, 32'h2);
    rd_cnt(5, d);     chk("R10 counter wrapped to zero", d, 0);
  endtask

  initial begin
    for (int w = 0; w < 4; w++) sel_sh[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_slot_layout();
    t_stop_wins();
    t_count();
    t_clear();
    t_cycle();
    t_preload();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule